// File: doc/BRIEF.md
# Expanded-Memory Page Window Mapper

This block sits beside the system bus of an 8088-class processor and lets software look at more RAM than fits below 1 MB. It holds four 16 KB window slots in the upper memory area between 0xC0000 and 0xFFFFF. Each slot has an 8-bit page register that enables it and picks the page of RAM it shows. Each slot also has an 8-bit control register. The top bits of the four control registers together form a 4-bit rotation index, and that index moves the windows to other 64 KB banks inside the upper memory area. The same index decides whether an option-ROM region stays visible.

Software reaches the eight registers through I/O cycles. The memory side is purely combinational. For every CPU memory address the block reports three things: whether an enabled window claims the address, the physical RAM address the access should go to, and whether that address lies inside the installed memory. The DRAM controller uses these to serve the access. It returns 0xFF on an out-of-range read and drops an out-of-range write. The register bank only responds when the installed memory is larger than 640 KB.

Top module: `ems_window_mapper`

## Requirements
- R1: After reset all four page registers read 0x7F, control registers 0, 1 and 2 read 0x80, control register 3 reads 0x00, and `rom_en` is 1.
- R2: I/O address bits 13:0 equal to 0x208 select a page register and 0x209 select a control register. Bits 15:14 pick register 0 to 3. A write on a rising clock edge with `io_wr` high stores `io_wdata`, and a read returns the stored value.
- R3: An I/O read of any other address returns 0xFF, and a write to any other address changes no register.
- R4: While `mem_kb` is 640 or less, every register read returns 0xFF and every write is ignored. The stored values reappear once `mem_kb` exceeds 640.
- R5: A window takes part only while bit 7 of its page register is 1. An address that no enabled window claims gives `win_hit` = 0 and `phys_addr` equal to `mem_addr` (zero-extended).
- R6: For a claimed address, with page register p chosen by `mem_addr[15:14]`, `phys_addr` = 0xA0000 + p[3:0]·0x4000 + p[6]·0x40000 + `mem_addr[13:0]`.
- R7: The index is {ctrl3[7], ctrl2[7], ctrl1[7], ctrl0[7]}. Window i covers the 16 KB starting at 0xC0000 + i·0x4000 + (((index + 4 − i) mod 16) AND 0xC)·0x4000.
- R8: `rom_en` is 0 while the index is below 3 and 1 otherwise.
- R9: `phys_ok` is 1 exactly when `phys_addr` is below `mem_kb`·1024.
- R10: A register write changes the memory-side outputs only after the clock edge that stores it. A lookup in the same cycle as the write still uses the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_kb | input | 11 | Installed memory size in KB |
| io_addr | input | 16 | I/O cycle address |
| io_wr | input | 1 | I/O write strobe, sampled on the rising edge |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| mem_addr | input | 20 | CPU memory-cycle address |
| win_hit | output | 1 | An enabled window claims `mem_addr` |
| phys_addr | output | 21 | Translated physical address |
| phys_ok | output | 1 | `phys_addr` lies inside installed memory |
| rom_en | output | 1 | Option-ROM region enable |

## Verification
Two things can happen in the same cycle: a register write is being stored, and a memory lookup is running against the current mapping. The bench provokes this by holding a control-register write and a window address together through one clock edge. The write moves window 0 away from the address being looked up. Just before the edge, the lookup must still be claimed at the old translation. Just after the edge, it must miss. The wider sweep walks all sixteen rotation indices against several page patterns and every 16 KB block from 0xB0000 up. It compares hit, address and range flag against a window model that searches each slot's span.

// File: rtl/ems_window_mapper.sv
module ems_window_mapper #(
  parameter int MIN_KB = 640,
  parameter int KB_W   = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [KB_W-1:0] mem_kb,
  input  logic [15:0]     io_addr,
  input  logic            io_wr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic [19:0]     mem_addr,
  output logic            win_hit,
  output logic [20:0]     phys_addr,
  output logic            phys_ok,
  output logic            rom_en
);
  localparam int LIM_W = KB_W + 10;

  logic [3:0][7:0] pg, ct;
  logic            io_en, sel_pg, sel_ct;
  logic [1:0]      io_slot, slot;
  logic [3:0]      idx, rot;
  logic [7:0]      p;
  logic [20:0]     trans;
  logic [LIM_W-1:0] lim;

  assign io_en   = mem_kb > KB_W'(MIN_KB);
  assign io_slot = io_addr[15:14];
  assign sel_pg  = io_addr[13:0] == 14'h208;
  assign sel_ct  = io_addr[13:0] == 14'h209;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        pg[i] <= 8'h7F;
        ct[i] <= (i == 3) ? 8'h00 : 8'h80;
      end
    end else if (io_wr && io_en) begin
      if (sel_pg) pg[io_slot] <= io_wdata;
      if (sel_ct) ct[io_slot] <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_en && sel_pg) io_rdata = pg[io_slot];
    if (io_en && sel_ct) io_rdata = ct[io_slot];
  end

  assign idx    = {ct[3][7], ct[2][7], ct[1][7], ct[0][7]};
  assign rom_en = idx >= 4'd3;

  assign slot    = mem_addr[15:14];
  assign p       = pg[slot];
  assign rot     = idx + 4'd4 - {2'b00, slot};
  assign win_hit = p[7] && (mem_addr[19:18] == 2'b11) && (mem_addr[17:16] == rot[3:2]);

  assign trans     = 21'h0A0000 + {3'b000, p[3:0], 14'b0} + {2'b00, p[6], 18'b0} + {7'b0, mem_addr[13:0]};
  assign phys_addr = win_hit ? trans : {1'b0, mem_addr};
  assign lim       = {mem_kb, 10'b0};
  assign phys_ok   = LIM_W'(phys_addr) < lim;

  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_en) |=> ($stable(pg) && $stable(ct))); // R4
  AST_PAGE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_en && sel_pg) |=> (pg[$past(io_slot)] == $past(io_wdata))); // R2
  AST_OTHER_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_pg && !sel_ct) |-> (io_rdata == 8'hFF)); // R3
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (pg[mem_addr[15:14]][7] && mem_addr[19:18] == 2'b11)); // R5
  AST_ROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_en |-> (!ct[3][7] && !ct[2][7])); // R8
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (phys_addr == {1'b0, mem_addr})); // R5
endmodule

// File: tb/test_ems_window_mapper.sv
module test_ems_window_mapper;
  logic        clk = 0, rst_n = 0;
  logic [10:0] mem_kb = 11'd1024;
  logic [15:0] io_addr = 0;
  logic        io_wr = 0;
  logic [7:0]  io_wdata = 0, io_rdata;
  logic [19:0] mem_addr = 0;
  logic        win_hit, phys_ok, rom_en;
  logic [20:0] phys_addr;

  int checks = 0, fails = 0;
  logic [7:0] m_pg [4];
  logic [7:0] m_ct [4];

  always #2 clk = ~clk;

  ems_window_mapper i_ems_window_mapper (
    .clk(clk), .rst_n(rst_n), .mem_kb(mem_kb), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr), .win_hit(win_hit),
    .phys_addr(phys_addr), .phys_ok(phys_ok), .rom_en(rom_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; #1 d = io_rdata;
  endtask

  function automatic logic [3:0] m_idx();
    return {m_ct[3][7], m_ct[2][7], m_ct[1][7], m_ct[0][7]};
  endfunction

  task automatic lookup(input logic [19:0] a);
    int base;
    int hit = 0;
    int ep;
    logic [3:0] ix = m_idx();
    ep = a;
    for (int i = 0; i < 4; i++) begin
      base = 32'hC0000 + i * 32'h4000 + (((ix + 4 - i) % 16) & 12) * 32'h4000;
      if (m_pg[i][7] && a >= base && a < base + 32'h4000) begin
        hit = 1;
        ep = 32'hA0000 + m_pg[i][3:0] * 32'h4000 + m_pg[i][6] * 32'h40000 + (a % 32'h4000);
      end
    end
    mem_addr = a; #1;
    chk(hit ? "R7 hit" : "R5 miss", win_hit, hit);
    chk("R6 phys", phys_addr, ep);
    chk("R9 range", phys_ok, ep < mem_kb * 1024);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 4; i++) begin m_pg[i] = 8'h7F; m_ct[i] = (i == 3) ? 8'h00 : 8'h80; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    for (int i = 0; i < 4; i++) begin
      rd(16'(i * 16'h4000 + 16'h208), d); chk("R1 page reset", d, 8'h7F);
      rd(16'(i * 16'h4000 + 16'h209), d); chk("R1 ctrl reset", d, (i == 3) ? 8'h00 : 8'h80);
    end
    chk("R1 rom_en reset", rom_en, 1);
    // R2 write/readback
    for (int i = 0; i < 4; i++) begin
      m_pg[i] = 8'h15 + 8'(i * 37); m_ct[i] = 8'h5A ^ 8'(i * 77);
      wr(16'(i * 16'h4000 + 16'h208), m_pg[i]);
      wr(16'(i * 16'h4000 + 16'h209), m_ct[i]);
    end
    for (int i = 0; i < 4; i++) begin
      rd(16'(i * 16'h4000 + 16'h208), d); chk("R2 page readback", d, m_pg[i]);
      rd(16'(i * 16'h4000 + 16'h209), d); chk("R2 ctrl readback", d, m_ct[i]);
    end
    // R3 other addresses
    wr(16'h1208, 8'h00); wr(16'h420A, 8'h00); wr(16'h0207, 8'h00);
    rd(16'h1208, d); chk("R3 stray read", d, 8'hFF);
    rd(16'h420A, d); chk("R3 stray read", d, 8'hFF);
    rd(16'h0207, d); chk("R3 stray read", d, 8'hFF);
    for (int i = 0; i < 4; i++) begin
      rd(16'(i * 16'h4000 + 16'h208), d); chk("R3 no side effect", d, m_pg[i]);
      rd(16'(i * 16'h4000 + 16'h209), d); chk("R3 no side effect", d, m_ct[i]);
    end
    // R4 small memory
    mem_kb = 11'd640;
    rd(16'h8208, d); chk("R4 blocked read", d, 8'hFF);
    wr(16'h8208, 8'hEE); wr(16'hC209, 8'hEE);
    mem_kb = 11'd641;
    rd(16'h8208, d); chk("R4 write ignored", d, m_pg[2]);
    rd(16'hC209, d); chk("R4 write ignored", d, m_ct[3]);
    // R5..R9 sweep
    for (int ix = 0; ix < 16; ix++) begin
      for (int i = 0; i < 4; i++) begin
        m_ct[i] = {ix[i], 7'(i * 9 + ix)};
        wr(16'(i * 16'h4000 + 16'h209), m_ct[i]);
      end
      rd(16'h4209, d); chk("R2 ctrl readback", d, m_ct[1]);
      chk("R8 rom_en", rom_en, ix >= 3);
      for (int k = 0; k < 4; k++) begin
        mem_kb = (k % 2) ? 11'd1536 : 11'd1024;
        for (int i = 0; i < 4; i++) begin
          m_pg[i] = {((i + k) % 3 != 0) ? 1'b1 : 1'b0, 1'((i * k) & 1), 2'b10, 4'(i * 5 + k * 3 + ix)};
          wr(16'(i * 16'h4000 + 16'h208), m_pg[i]);
        end
        @(negedge clk);
        for (int b = 0; b < 20; b++)
          lookup(20'(32'hB0000 + b * 32'h4000 + ((b * 32'h1357 + ix) % 32'h4000)));
      end
    end
    // R10 same-cycle write and lookup
    for (int i = 0; i < 4; i++) begin m_ct[i] = 8'h00; wr(16'(i * 16'h4000 + 16'h209), 8'h00); end
    m_pg[0] = 8'h81; wr(16'h0208, 8'h81);
    @(negedge clk);
    mem_addr = 20'hD0010; io_addr = 16'hC209; io_wdata = 8'h80; io_wr = 1;
    #1 chk("R10 old mapping before edge", win_hit, 1);
    chk("R10 old phys before edge", phys_addr, 21'hA4010);
    @(posedge clk); #1 chk("R10 new mapping after edge", win_hit, 0);
    @(negedge clk); io_wr = 0; m_ct[3] = 8'h80;
    lookup(20'hF0020);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule